// File: doc/BRIEF.md
# Four-Phase Timed Signal Head Sequencer

This block drives one signal head through a fixed loop of four phases: go (green lamp), caution (yellow lamp), stop (red lamp) and a blinking stop phase in which the red lamp flashes. Time is counted in ticks. A tick is a one-cycle enable pulse made elsewhere, for example by a clock divider. Each phase has its own dwell length. A down-counter sets how long the current phase lasts and allows a phase change only when it has reached zero.

The lamps are a Moore function. They depend on the current phase and, in the blinking phase, on the low bit of the dwell counter. No input reaches them directly. An active-low asynchronous reset puts the head back to green at once, without waiting for a tick. This matters when ticks are seconds apart.

Named states: `PH_GO`, `PH_CAUTION`, `PH_STOP`, `PH_BLINK`. Named transitions:
- go→caution
- caution→stop
- stop→blink
- blink→go

Each transition is taken on a tick that finds the dwell counter at zero. The default branch of the next-state logic returns to go.

Top module: `signal_head_seq`

## Requirements
- R1: The phase order is go → caution → stop → blink → go, repeating indefinitely.
- R2: Dwell lengths in ticks are go 6, caution 2, stop 6 and blink 4. On entering a phase, the counter is loaded with the length minus one and counts down to zero inclusive.
- R3: A tick that finds the counter non-zero only decrements it, and the phase holds. A tick that finds it zero advances the phase and reloads the counter for the new phase.
- R4: Cycles without a tick change neither the phase nor the counter, so the lamps hold.
- R5: Driving `rst_n` low forces the go phase and the go dwell load immediately, without a clock edge. While `rst_n` is held low, ticks have no effect.
- R6: In go, caution and stop, exactly one lamp is lit: green, yellow and red respectively.
- R7: In blink, green and yellow are off and red equals bit 0 of the dwell counter. It is therefore lit on the first and third blink ticks and dark on the second and fourth.
- R8: One full loop takes 18 ticks. Counted from reset, tick number k shows the same lamps as tick k+18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle timing enable |
| lamp_grn | output | 1 | Green lamp drive |
| lamp_ylw | output | 1 | Yellow lamp drive |
| lamp_red | output | 1 | Red lamp drive |

## Verification
A wrong phase shows at the lamps right after the tick that produced it, because each phase other than blink lights its own lamp. A wrong dwell count stays hidden until that phase ends. It then shows as a lamp change one or more ticks early or late, or as a blink pattern that starts dark or has the wrong number of flashes. The bench counts ticks from reset and compares every lamp after every tick, over more than two loops. It puts idle gaps of different lengths between ticks. It also asserts reset in the middle of the stop phase and checks that the lamps turn green before the next clock edge.

// File: rtl/sig_head_pkg.sv
package sig_head_pkg;
    typedef enum logic [1:0] {
        PH_GO      = 2'd0,
        PH_CAUTION = 2'd1,
        PH_STOP    = 2'd2,
        PH_BLINK   = 2'd3
    } phase_e;
endpackage

// File: rtl/sig_dwell_ctr.sv
module sig_dwell_ctr #(
    parameter int          CNT_W   = 3,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cnt_zero
);
    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (tick) begin
            if (cnt_zero) cnt_q <= load_val;
            else          cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sig_phase_fsm.sv
module sig_phase_fsm
    import sig_head_pkg::*;
#(
    parameter int CNT_W       = 3,
    parameter int GO_TICKS    = 6,
    parameter int CAUT_TICKS  = 2,
    parameter int STOP_TICKS  = 6,
    parameter int BLINK_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_zero,
    output phase_e           phase_q,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [CNT_W-1:0] LD_GO    = CNT_W'(GO_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_CAUT  = CNT_W'(CAUT_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_STOP  = CNT_W'(STOP_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_BLINK = CNT_W'(BLINK_TICKS - 1);

    phase_e phase_nx;

    // next-state: fixed loop, default returns to go
    always_comb begin
        unique case (phase_q)
            PH_GO:      phase_nx = PH_CAUTION;
            PH_CAUTION: phase_nx = PH_STOP;
            PH_STOP:    phase_nx = PH_BLINK;
            PH_BLINK:   phase_nx = PH_GO;
            default:    phase_nx = PH_GO;
        endcase
    end

    // dwell load for the phase about to be entered
    always_comb begin
        unique case (phase_nx)
            PH_GO:      load_val = LD_GO;
            PH_CAUTION: load_val = LD_CAUT;
            PH_STOP:    load_val = LD_STOP;
            PH_BLINK:   load_val = LD_BLINK;
            default:    load_val = LD_GO;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                phase_q <= PH_GO;
        else if (tick && cnt_zero) phase_q <= phase_nx;
    end
endmodule

// File: rtl/sig_lamp_dec.sv
module sig_lamp_dec
    import sig_head_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  phase_e           phase_q,
    input  logic [CNT_W-1:0] cnt_q,
    output logic             lamp_grn,
    output logic             lamp_ylw,
    output logic             lamp_red
);
    always_comb begin
        lamp_grn = 1'b0;
        lamp_ylw = 1'b0;
        lamp_red = 1'b0;
        unique case (phase_q)
            PH_GO:      lamp_grn = 1'b1;
            PH_CAUTION: lamp_ylw = 1'b1;
            PH_STOP:    lamp_red = 1'b1;
            PH_BLINK:   lamp_red = cnt_q[0];
            default:    lamp_red = 1'b1;
        endcase
    end
endmodule

// File: rtl/signal_head_seq.sv
module signal_head_seq
    import sig_head_pkg::*;
#(
    parameter int GO_TICKS    = 6,
    parameter int CAUT_TICKS  = 2,
    parameter int STOP_TICKS  = 6,
    parameter int BLINK_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic lamp_grn,
    output logic lamp_ylw,
    output logic lamp_red
);
    localparam int MAX_A  = (GO_TICKS > CAUT_TICKS) ? GO_TICKS : CAUT_TICKS;
    localparam int MAX_B  = (STOP_TICKS > BLINK_TICKS) ? STOP_TICKS : BLINK_TICKS;
    localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = (MAX_T > 2) ? $clog2(MAX_T) : 1;

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             cnt_zero;

    sig_phase_fsm #(
        .CNT_W(CNT_W), .GO_TICKS(GO_TICKS), .CAUT_TICKS(CAUT_TICKS),
        .STOP_TICKS(STOP_TICKS), .BLINK_TICKS(BLINK_TICKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_zero(cnt_zero),
        .phase_q(phase_q), .load_val(load_val)
    );

    sig_dwell_ctr #(
        .CNT_W(CNT_W), .RST_VAL(CNT_W'(GO_TICKS - 1))
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_val(load_val),
        .cnt_q(cnt_q), .cnt_zero(cnt_zero)
    );

    sig_lamp_dec #(.CNT_W(CNT_W)) u_dec (
        .phase_q(phase_q), .cnt_q(cnt_q),
        .lamp_grn(lamp_grn), .lamp_ylw(lamp_ylw), .lamp_red(lamp_red)
    );
endmodule

// File: rtl/sig_head_checker.sv
module sig_head_checker
    import sig_head_pkg::*;
#(
    parameter int CNT_W       = 3,
    parameter int GO_TICKS    = 6,
    parameter int CAUT_TICKS  = 2,
    parameter int STOP_TICKS  = 6,
    parameter int BLINK_TICKS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input phase_e           phase,
    input logic [CNT_W-1:0] cnt,
    input logic             lamp_grn,
    input logic             lamp_ylw,
    input logic             lamp_red
);
    // R1 / R2: transitions in order, each loading the new dwell
    a_r1_go_to_caution: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && phase == PH_GO) |=>
            (phase == PH_CAUTION && cnt == CNT_W'(CAUT_TICKS - 1)));
    a_r1_caution_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && phase == PH_CAUTION) |=>
            (phase == PH_STOP && cnt == CNT_W'(STOP_TICKS - 1)));
    a_r1_stop_to_blink: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && phase == PH_STOP) |=>
            (phase == PH_BLINK && cnt == CNT_W'(BLINK_TICKS - 1)));
    a_r2_blink_to_go: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && phase == PH_BLINK) |=>
            (phase == PH_GO && cnt == CNT_W'(GO_TICKS - 1)));
    // R3: non-zero count only decrements
    a_r3_hold_and_count: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0) |=> ($stable(phase) && cnt == $past(cnt) - 1'b1));
    // R4: no tick, no change
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(phase) && $stable(cnt)));
    // R6: steady phases light one lamp
    a_r6_one_lamp: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_BLINK) |-> $onehot({lamp_grn, lamp_ylw, lamp_red}));
    // R7: blink phase keeps green and yellow dark
    a_r7_blink_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BLINK) |-> (!lamp_grn && !lamp_ylw));
    // R7: red toggles on every blink tick that does not leave the phase
    a_r7_blink_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BLINK && tick && cnt != '0) |=> (lamp_red != $past(lamp_red)));
endmodule

bind signal_head_seq sig_head_checker #(
    .CNT_W(CNT_W), .GO_TICKS(GO_TICKS), .CAUT_TICKS(CAUT_TICKS),
    .STOP_TICKS(STOP_TICKS), .BLINK_TICKS(BLINK_TICKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase_q), .cnt(cnt_q),
    .lamp_grn(lamp_grn), .lamp_ylw(lamp_ylw), .lamp_red(lamp_red)
);

// File: tb/signal_head_seq_test.sv
`timescale 1ns/1ps
module signal_head_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic lamp_grn, lamp_ylw, lamp_red;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    signal_head_seq uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .lamp_grn(lamp_grn), .lamp_ylw(lamp_ylw), .lamp_red(lamp_red)
    );

    // expected {grn,ylw,red} after k ticks since reset
    function automatic logic [2:0] expect_lamps(int k);
        int m = k % 18;
        if (m < 6)  return 3'b100;
        if (m < 8)  return 3'b010;
        if (m < 14) return 3'b001;
        return {2'b00, 1'(((17 - m) % 2))};
    endfunction

    task automatic check(string req, logic [2:0] exp);
        logic [2:0] act = {lamp_grn, lamp_ylw, lamp_red};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: lamps grn/ylw/red actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        #35 rst_n = 1'b1;
        #1;
        check("R5 reset state", 3'b100);

        // R1 R2 R3 R6 R7 R8: more than two loops, varied idle gaps (R4)
        for (int k = 1; k <= 40; k++) begin
            pulse_tick();
            check("R1/R2/R3/R6/R7/R8 tick sequence", expect_lamps(k));
            idle(k % 3);
            check("R4 idle holds lamps", expect_lamps(k));
        end

        // 40 ticks: m=4 (go). Advance into stop at k=50 (m=14? no: 50%18=14 blink)
        for (int k = 41; k <= 46; k++) begin
            pulse_tick();
            check("R1 sequence before reset", expect_lamps(k));
        end
        // k=46 -> m=10, stop phase mid-dwell
        check("R6 stop lamp before reset", 3'b001);

        // R5: asynchronous reset away from a clock edge
        @(negedge clk);
        #3 rst_n = 1'b0;
        #2;
        check("R5 async reset forces green before edge", 3'b100);
        @(negedge clk) tick = 1'b1;
        idle(3);
        tick = 1'b0;
        check("R5 ticks ignored in reset", 3'b100);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R5 green after release", 3'b100);

        // R2 R8: fresh go dwell and a full loop after reset
        for (int k = 1; k <= 19; k++) begin
            pulse_tick();
            check("R2/R8 sequence after mid-phase reset", expect_lamps(k));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule